// File: doc/BRIEF.md
# Stack-Based Bit-Serial Processing Element

This block is the one-bit compute cell of a wide SIMD array. A copy sits beside each data column of a RAM array, and every copy receives the same instruction in the same cycle. Each element works on its own column in place: it reads one RAM bit, combines it with its own stack and carry state, and may write one bit back. Multi-bit operations such as addition run one bit per instruction, with the sequencer outside the block stepping the column address.

The operation is not a fixed opcode. It is a 16-entry truth table carried in the instruction and indexed by four bits: the RAM bit, the top of stack, the entry below it, and an auxiliary bit that is either a constant from the instruction or the element's carry register. The result can go to the top of stack, to the RAM column and to the element's enable flag, in any combination. A circular bit stack with push and pop, a carry register for add-with-carry and a per-element enable flag complete the cell. The RAM macro and the address generation are outside the block. The RAM bit arrives as an input, and the write strobe and write data leave as outputs.

Top module: `bsp_pe`

## Requirements
- R1: After reset the top and second stack entries, every deeper entry and the carry are 0, the enable flag is 1, and the write strobe is low.
- R2: The result is bit `idx` of the table field `instr[15:0]`, with `idx = {ram_rdata, top, second, aux}`. Here `ram_rdata` is bit 3 and `aux` is bit 0. Whenever `instr_valid` is high, `ram_wdata` shows this result in the same cycle.
- R3: The aux bit is the constant `instr[17]` when `instr[16]` is 0, and is the carry register when `instr[16]` is 1.
- R4: On an executed instruction, `instr[19]` clears the carry. Otherwise `instr[18]` loads the carry with the majority of the RAM bit, the top and the old carry. The clear takes priority.
- R5: An executed instruction with `instr[20]` set and no stack move puts the result on top and leaves the second entry unchanged, one cycle later.
- R6: With `instr[21]` set on an executed instruction, `ram_we` is high in that same cycle and `ram_wdata` carries the result.
- R7: An executed instruction with `instr[22]` set loads the enable flag with the result.
- R8: An instruction with `instr[23]` set sets the enable flag even on a disabled element, and it wins over `instr[22]`.
- R9: When `instr_valid` is low or the element is disabled, the stack, the carry and the enable flag stay unchanged and `ram_we` stays low. The only exception is R8.
- R10: A push (`instr[24]`) moves every entry one deeper. The new top is the result if `instr[20]` is set, and otherwise a copy of the old top.
- R11: A pop (`instr[25]`) moves every entry one place up. The old top goes into the deepest slot. If `instr[20]` is set, the result then overwrites the new top.
- R12: Push and pop requested together move nothing. Only `instr[20]` acts, as in R5.
- R13: The stack is circular with `STACK_DEPTH` entries (a power of two). A push beyond the depth overwrites the oldest entry without any flag, and a pop beyond the depth returns entries in circular order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | Broadcast instruction present this cycle |
| instr | input | 26 | Broadcast instruction word |
| ram_rdata | input | 1 | Bit read from this element's column |
| ram_we | output | 1 | Write strobe for this element's column |
| ram_wdata | output | 1 | Computed result bit, written when `ram_we` is high |
| tos_o | output | 1 | Top stack entry |
| nos_o | output | 1 | Second stack entry |
| carry_o | output | 1 | Carry register |
| pe_en_o | output | 1 | Element enable flag |

## Verification
The bench builds the element with the default `STACK_DEPTH` of 8. At that depth, nine pushes followed by eight pops run the stack through both overflow and underflow, and each entry that the pointer wrap touches comes back out on the top and second outputs. A five-bit serial add (11 + 6) drives the carry through every state of the majority update, and sequences that disable the element, retry work and then re-enable it cover the freeze and its single exception.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
  localparam int LUT_IN = 4;
  localparam int LUT_W  = 1 << LUT_IN;

  typedef struct packed {
    logic             pop;
    logic             push;
    logic             en_set;
    logic             wr_en;
    logic             wr_ram;
    logic             wr_tos;
    logic             carry_clr;
    logic             carry_upd;
    logic             konst;
    logic             aux_sel;
    logic [LUT_W-1:0] lut;
  } instr_t;

  localparam int INSTR_W = $bits(instr_t);

  function automatic logic lut_pick(input logic [LUT_W-1:0] table_bits,
                                    input logic [LUT_IN-1:0] idx);
    return table_bits[idx];
  endfunction

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/bsp_lut.sv
module bsp_lut
  import bsp_pkg::*;
(
  input  logic [LUT_W-1:0] lut_i,
  input  logic             ram_i,
  input  logic             tos_i,
  input  logic             nos_i,
  input  logic             aux_sel_i,
  input  logic             konst_i,
  input  logic             carry_i,
  output logic             result_o
);
  logic              aux_w;
  logic [LUT_IN-1:0] idx_w;

  assign aux_w    = aux_sel_i ? carry_i : konst_i;
  assign idx_w    = {ram_i, tos_i, nos_i, aux_w};
  assign result_o = lut_pick(lut_i, idx_w);
endmodule

// File: rtl/bsp_carry.sv
module bsp_carry
  import bsp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic clr_i,
  input  logic upd_i,
  input  logic ram_i,
  input  logic tos_i,
  output logic carry_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      carry_o <= 1'b0;
    end else if (fire_i) begin
      if (clr_i)      carry_o <= 1'b0;
      else if (upd_i) carry_o <= maj3(ram_i, tos_i, carry_o);
    end
  end
endmodule

// File: rtl/bsp_bitstack.sv
module bsp_bitstack #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic push_i,
  input  logic pop_i,
  input  logic wr_top_i,
  input  logic din_i,
  output logic tos_o,
  output logic nos_o
);
  localparam int PTR_W = (DEPTH > 2) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] mem_q;
  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] up_w;
  logic [PTR_W-1:0] dn_w;

  assign up_w  = ptr_q + 1'b1;
  assign dn_w  = ptr_q - 1'b1;
  assign tos_o = mem_q[ptr_q];
  assign nos_o = mem_q[dn_w];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_q <= '0;
      ptr_q <= '0;
    end else if (fire_i) begin
      unique case ({push_i, pop_i})
        2'b10: begin
          mem_q[up_w] <= wr_top_i ? din_i : mem_q[ptr_q];
          ptr_q       <= up_w;
        end
        2'b01: begin
          if (wr_top_i) mem_q[dn_w] <= din_i;
          ptr_q <= dn_w;
        end
        default: begin
          if (wr_top_i) mem_q[ptr_q] <= din_i;
        end
      endcase
    end
  end
endmodule

// File: rtl/bsp_pe.sv
module bsp_pe
  import bsp_pkg::*;
#(
  parameter int STACK_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr,
  input  logic               ram_rdata,
  output logic               ram_we,
  output logic               ram_wdata,
  output logic               tos_o,
  output logic               nos_o,
  output logic               carry_o,
  output logic               pe_en_o
);
  instr_t op;
  logic   pe_en_q;
  logic   exec_fire;
  logic   result_w;
  logic   cmd_push, cmd_pop, cmd_wr_tos, cmd_clr, cmd_en_set;

  assign op         = instr_t'(instr);
  assign exec_fire  = instr_valid & pe_en_q;
  assign cmd_push   = op.push;
  assign cmd_pop    = op.pop;
  assign cmd_wr_tos = op.wr_tos;
  assign cmd_clr    = op.carry_clr;
  assign cmd_en_set = instr_valid & op.en_set;

  bsp_lut u_lut (
    .lut_i     (op.lut),
    .ram_i     (ram_rdata),
    .tos_i     (tos_o),
    .nos_i     (nos_o),
    .aux_sel_i (op.aux_sel),
    .konst_i   (op.konst),
    .carry_i   (carry_o),
    .result_o  (result_w)
  );

  bsp_carry u_carry (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire_i  (exec_fire),
    .clr_i   (op.carry_clr),
    .upd_i   (op.carry_upd),
    .ram_i   (ram_rdata),
    .tos_i   (tos_o),
    .carry_o (carry_o)
  );

  bsp_bitstack #(.DEPTH(STACK_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire_i   (exec_fire),
    .push_i   (op.push),
    .pop_i    (op.pop),
    .wr_top_i (op.wr_tos),
    .din_i    (result_w),
    .tos_o    (tos_o),
    .nos_o    (nos_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                      pe_en_q <= 1'b1;
    else if (cmd_en_set)             pe_en_q <= 1'b1;
    else if (exec_fire && op.wr_en)  pe_en_q <= result_w;
  end

  assign pe_en_o   = pe_en_q;
  assign ram_we    = exec_fire & op.wr_ram;
  assign ram_wdata = result_w;
endmodule

// File: rtl/bsp_pe_chk.sv
module bsp_pe_chk (
  input logic clk,
  input logic rst_n,
  input logic instr_valid,
  input logic exec_fire,
  input logic cmd_push,
  input logic cmd_pop,
  input logic cmd_wr_tos,
  input logic cmd_clr,
  input logic cmd_en_set,
  input logic result_w,
  input logic tos_o,
  input logic nos_o,
  input logic carry_o,
  input logic pe_en_o
);
  assert_en_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_en_set |=> pe_en_o);

  assert_carry_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && cmd_clr) |=> !carry_o);

  assert_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!exec_fire && !cmd_en_set) |=>
      ($stable(tos_o) && $stable(nos_o) && $stable(carry_o) && $stable(pe_en_o)));

  assert_push_dup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && cmd_push && !cmd_pop && !cmd_wr_tos) |=>
      (tos_o == $past(tos_o) && nos_o == $past(tos_o)));

  assert_pop_lift_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && cmd_pop && !cmd_push && !cmd_wr_tos) |=> (tos_o == $past(nos_o)));

  assert_top_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_fire && cmd_wr_tos && (cmd_push == cmd_pop)) |=>
      (tos_o == $past(result_w) && $stable(nos_o)));

  always_comb begin
    if (rst_n && !instr_valid) assert_no_fire_R9: assert (!exec_fire);
  end
endmodule

bind bsp_pe bsp_pe_chk u_bsp_pe_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .instr_valid (instr_valid),
  .exec_fire   (exec_fire),
  .cmd_push    (cmd_push),
  .cmd_pop     (cmd_pop),
  .cmd_wr_tos  (cmd_wr_tos),
  .cmd_clr     (cmd_clr),
  .cmd_en_set  (cmd_en_set),
  .result_w    (result_w),
  .tos_o       (tos_o),
  .nos_o       (nos_o),
  .carry_o     (carry_o),
  .pe_en_o     (pe_en_o)
);

// File: tb/test_bsp_pe.sv
module test_bsp_pe;
  localparam int DEPTH = 8;
  localparam int IW    = bsp_pkg::INSTR_W;
  localparam int F_AUX = 0, F_RAM = 1, F_AND = 2, F_OR = 3, F_XOR = 4,
                 F_NOT = 5, F_TN = 6, F_SUM = 7, F_ZERO = 8, F_ONE = 9;

  logic clk = 1'b0, rst_n = 1'b0, instr_valid = 1'b0, ram_rdata = 1'b0;
  logic [IW-1:0] instr = '0;
  logic ram_we, ram_wdata, tos_o, nos_o, carry_o, pe_en_o;

  always #2 clk = ~clk;

  bsp_pe #(.STACK_DEPTH(DEPTH)) i_bsp_pe (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_wdata(ram_wdata),
    .tos_o(tos_o), .nos_o(nos_o), .carry_o(carry_o), .pe_en_o(pe_en_o)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  typedef struct { string req; logic tos; logic nos; logic cy; logic en; } exp_t;
  exp_t sbq[$];
  logic m_stk [DEPTH];
  logic m_cy, m_en, last_wdata;

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] lut_of(int f);
    logic [15:0] t;
    for (int i = 0; i < 16; i++) begin
      bit r, s, n, a, v;
      r = (i / 8) % 2; s = (i / 4) % 2; n = (i / 2) % 2; a = i % 2;
      case (f)
        F_AUX:   v = a;
        F_RAM:   v = r;
        F_AND:   v = r && s;
        F_OR:    v = r || s;
        F_XOR:   v = r != s;
        F_NOT:   v = !s;
        F_TN:    v = s && n;
        F_SUM:   v = ((r + s + a) % 2) == 1;
        F_ZERO:  v = 0;
        default: v = 1;
      endcase
      t[i] = v;
    end
    return t;
  endfunction

  function automatic logic [IW-1:0] mk(int f, bit auxs, bit k, bit cupd, bit cclr,
      bit wtos, bit wram, bit wen, bit eset, bit psh, bit pp);
    return {pp, psh, eset, wen, wram, wtos, cclr, cupd, k, auxs, lut_of(f)};
  endfunction

  task automatic issue(string req, logic [IW-1:0] ins, logic rd, bit vld = 1);
    logic [15:0] lut;
    bit auxs, k, cupd, cclr, wtos, wram, wen, eset, psh, pp, fire, aux, res, old_top;
    lut = ins[15:0]; auxs = ins[16]; k = ins[17]; cupd = ins[18]; cclr = ins[19];
    wtos = ins[20]; wram = ins[21]; wen = ins[22]; eset = ins[23]; psh = ins[24]; pp = ins[25];
    @(negedge clk);
    instr = ins; instr_valid = vld; ram_rdata = rd;
    #1;
    fire = vld && m_en;
    aux  = auxs ? m_cy : k;
    res  = ((lut >> (8 * rd + 4 * m_stk[0] + 2 * m_stk[1] + aux)) & 16'd1) != 0;
    chk({req, "/R6"}, "ram_we", ram_we, fire && wram);
    if (vld) chk({req, "/R2"}, "ram_wdata", ram_wdata, res);
    last_wdata = ram_wdata;
    old_top = m_stk[0];
    if (fire) begin
      if (psh && !pp) begin
        for (int i = DEPTH - 1; i > 0; i--) m_stk[i] = m_stk[i-1];
        if (wtos) m_stk[0] = res;
      end else if (pp && !psh) begin
        for (int i = 0; i < DEPTH - 1; i++) m_stk[i] = m_stk[i+1];
        m_stk[DEPTH-1] = old_top;
        if (wtos) m_stk[0] = res;
      end else if (wtos) m_stk[0] = res;
      if (cclr) m_cy = 0;
      else if (cupd) m_cy = (rd + old_top + m_cy) >= 2;
      if (eset) m_en = 1;
      else if (wen) m_en = res;
    end else if (vld && eset) m_en = 1;
    sbq.push_back('{req, m_stk[0], m_stk[1], m_cy, m_en});
    @(posedge clk);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        chk(e.req, "tos", tos_o, e.tos);
        chk(e.req, "nos", nos_o, e.nos);
        chk(e.req, "carry", carry_o, e.cy);
        chk(e.req, "enable", pe_en_o, e.en);
      end
    end
  end

  initial begin : watchdog
    #800000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    logic [4:0] sum;
    for (int i = 0; i < DEPTH; i++) m_stk[i] = 0;
    m_cy = 0; m_en = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "tos", tos_o, 0);       chk("R1", "nos", nos_o, 0);
    chk("R1", "carry", carry_o, 0);   chk("R1", "enable", pe_en_o, 1);
    chk("R1", "ram_we", ram_we, 0);
    rst_n = 1'b1;
    // R1: deep entries are zero, seen by popping
    issue("R1", mk(F_AUX,0,0,0,0,0,0,0,0,0,1), 0);
    issue("R1", mk(F_AUX,0,0,0,0,0,0,0,0,0,1), 0);
    // R10 and R3: push constants
    issue("R10", mk(F_AUX,0,1,0,0,1,0,0,0,1,0), 0);
    issue("R10", mk(F_AUX,0,0,0,0,1,0,0,0,1,0), 0);
    issue("R3",  mk(F_AUX,0,1,0,0,1,0,0,0,1,0), 0);
    issue("R10", mk(F_AUX,0,0,0,0,0,0,0,0,1,0), 0);
    // R2 and R5: logic on RAM bit and top
    issue("R5", mk(F_OR, 0,0,0,0,1,0,0,0,0,0), 1);
    issue("R2", mk(F_AND,0,0,0,0,1,0,0,0,0,0), 0);
    issue("R2", mk(F_XOR,0,0,0,0,1,0,0,0,0,0), 1);
    issue("R2", mk(F_XOR,0,0,0,0,1,0,0,0,0,0), 1);
    issue("R2", mk(F_NOT,0,0,0,0,1,0,0,0,0,0), 0);
    issue("R6", mk(F_RAM,0,0,0,0,0,1,0,0,0,0), 1);
    issue("R6", mk(F_NOT,0,0,0,0,0,1,0,0,0,0), 0);
    // R11: binary op consuming the second entry, plain pop
    issue("R11", mk(F_TN, 0,0,0,0,1,0,0,0,0,1), 0);
    issue("R11", mk(F_AUX,0,0,0,0,0,0,0,0,0,1), 0);
    // R12: push and pop together
    issue("R12", mk(F_NOT,0,0,0,0,1,0,0,0,1,1), 0);
    issue("R12", mk(F_AUX,0,1,0,0,0,0,0,0,1,1), 0);
    // R4: five-bit serial add, 11 + 6
    issue("R4", mk(F_ONE,0,0,1,0,0,0,0,0,0,0), 1);
    issue("R4", mk(F_ONE,0,0,0,1,0,0,0,0,0,0), 0);
    for (int b = 0; b < 5; b++) begin
      issue("R10", mk(F_AUX,0,((11 >> b) & 1),0,0,1,0,0,0,1,0), 0);
      issue("R4",  mk(F_SUM,1,0,1,0,0,1,0,0,0,1), ((6 >> b) & 1));
      sum[b] = last_wdata;
    end
    chk("R4", "serial sum", sum, 17);
    issue("R3", mk(F_AUX,1,0,0,0,1,0,0,0,0,0), 0);
    // R9: valid low ignores everything
    issue("R9", mk(F_ONE,0,0,1,0,1,1,1,0,1,0), 1, 0);
    // R7 then R9: disable and attempt work
    issue("R7", mk(F_ZERO,0,0,0,0,0,0,1,0,0,0), 0);
    issue("R9", mk(F_ONE,0,0,1,0,1,1,0,0,1,0), 1);
    issue("R9", mk(F_ONE,0,0,0,0,1,1,1,0,0,1), 1);
    issue("R9", mk(F_AUX,0,0,0,1,1,0,0,0,0,0), 1);
    issue("R8", mk(F_ZERO,0,0,0,0,0,0,1,1,0,0), 0);
    issue("R8", mk(F_ZERO,0,0,0,0,0,0,1,1,0,0), 0);
    issue("R7", mk(F_RAM,0,0,0,0,0,0,1,0,0,0), 1);
    // R13: nine pushes, eight pops
    for (int p = 0; p < DEPTH + 1; p++)
      issue("R13", mk(F_AUX,0,((9'h1A5 >> p) & 1),0,0,1,0,0,0,1,0), 0);
    for (int p = 0; p < DEPTH; p++)
      issue("R13", mk(F_AUX,0,0,0,0,0,0,0,0,0,1), 0);
    @(negedge clk);
    instr_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule